// File: doc/BRIEF.md
# Self-Timed Page Erase/Program Sequencer

This block is the internal engine that carries out page-wide operations between a page-sized data buffer and a main memory array. Both storage elements sit inside the block. A host fills the buffer byte by byte and then starts an operation on a chosen page. A **program** operation first sets every byte of the page to all ones and then copies the buffer into it. A **rewrite** operation first copies the page into the buffer and then programs the buffer back into the same page. This refreshes the page and leaves its contents unchanged.

Each phase runs on a cycle counter whose length is a parameter, which models a self-timed erase or program duration. The copy work in each phase moves one byte per clock, and the rest of the phase is spent waiting. While an operation is running, `ready` stays low. New requests and host buffer writes are dropped during that time. Both arrays can be read at any time through combinational read ports, so the host can observe progress.

Top module: `page_op_seq`

## Requirements
- R1: After reset, `ready` is 1 and every byte of the main memory and of the buffer reads 8'hFF.
- R2: A request is accepted only on a clock edge where `ready` and `req_valid` are both 1. `req_rewrite`=0 selects program and `req_rewrite`=1 selects rewrite. `ready` is 0 in the cycle after acceptance.
- R3: When a program operation on page `req_page` ends, that page holds the buffer contents byte for byte, and every other page is unchanged.
- R4: A program operation erases before it programs. In the first cycle after the erase phase, every byte of the target page reads 8'hFF.
- R5: When a rewrite operation ends, the buffer holds the former contents of the target page, and the main memory is unchanged.
- R6: `ready` stays 0 for exactly ERASE_CYCLES+PROG_CYCLES+1 cycles for a program operation, and for PAGE_BYTES+ERASE_CYCLES+PROG_CYCLES+1 cycles for a rewrite operation. It is 1 again in the cycle after the final one-cycle done state.
- R7: A request that arrives while `ready` is 0 is dropped. It changes neither the page being processed nor any other page, and it starts no later operation.
- R8: A host buffer write (`buf_wr_en`=1) lands at `buf_wr_addr` only when `ready` is 1. While busy, such a write has no effect on the buffer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start an operation |
| req_rewrite | input | 1 | 0 = program, 1 = rewrite |
| req_page | input | PAW | Target page index |
| ready | output | 1 | 1 when idle and able to accept work |
| buf_wr_en | input | 1 | Host buffer byte write |
| buf_wr_addr | input | BAW | Buffer byte offset to write |
| buf_wr_data | input | DW | Buffer byte value |
| buf_rd_addr | input | BAW | Buffer byte offset to read |
| buf_rd_data | output | DW | Buffer byte at `buf_rd_addr` |
| mem_rd_page | input | PAW | Main memory page to read |
| mem_rd_offs | input | BAW | Byte offset within that page |
| mem_rd_data | output | DW | Main memory byte at the selected location |

## Verification
Program operations are run with random buffer fills, some of them partial, on random pages. This separates a correct copy from a stale buffer byte, a wrong page index, or a write that leaks into a neighbouring page. Rewrite operations are run after the buffer has been filled with values that differ from the page, which shows whether the load phase really overwrites the buffer and whether memory survives the round trip. Some program runs carry a request and a buffer write injected mid-operation, which exposes a block that accepts work while busy. Every run also counts busy cycles and takes a snapshot at the erase-to-program boundary. Together these check phase lengths and the erase-first ordering.

// File: rtl/page_seq_pkg.sv
package page_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LOAD  = 3'd1,
    ST_ERASE = 3'd2,
    ST_PROG  = 3'd3,
    ST_DONE  = 3'd4
  } seq_state_t;

  // Flat main-memory index of a byte within a page.
  function automatic int flat_index(input int page, input int offs, input int page_bytes);
    return page * page_bytes + offs;
  endfunction

  // Number of cycles spent in a given state.
  function automatic int phase_cycles(input seq_state_t st, input int pb,
                                      input int ec, input int pc);
    case (st)
      ST_LOAD:  return pb;
      ST_ERASE: return ec;
      ST_PROG:  return pc;
      default:  return 1;
    endcase
  endfunction

endpackage

// File: rtl/page_seq_timer.sv
module page_seq_timer #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic [CW-1:0] phase_len,
  output logic [CW-1:0] cnt,
  output logic          last
);

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end

  assign last = (cnt == phase_len - 1'b1);

endmodule

// File: rtl/page_seq_array.sv
module page_seq_array #(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  parameter int AW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [DW-1:0] rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_b
);

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
    end else if (we) begin
      cells[waddr] <= wdata;
    end
  end

  assign rdata_a = cells[raddr_a];
  assign rdata_b = cells[raddr_b];

endmodule

// File: rtl/page_op_seq.sv
module page_op_seq
  import page_seq_pkg::*;
#(
  parameter int DW           = 8,
  parameter int PAGE_BYTES   = 8,
  parameter int PAGE_COUNT   = 4,
  parameter int ERASE_CYCLES = 12,
  parameter int PROG_CYCLES  = 10,
  localparam int BAW    = $clog2(PAGE_BYTES),
  localparam int PAW    = $clog2(PAGE_COUNT),
  localparam int MDEPTH = PAGE_BYTES * PAGE_COUNT,
  localparam int MAW    = $clog2(MDEPTH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  input  logic           req_rewrite,
  input  logic [PAW-1:0] req_page,
  output logic           ready,
  input  logic           buf_wr_en,
  input  logic [BAW-1:0] buf_wr_addr,
  input  logic [DW-1:0]  buf_wr_data,
  input  logic [BAW-1:0] buf_rd_addr,
  output logic [DW-1:0]  buf_rd_data,
  input  logic [PAW-1:0] mem_rd_page,
  input  logic [BAW-1:0] mem_rd_offs,
  output logic [DW-1:0]  mem_rd_data
);

  localparam int MAXLEN = (ERASE_CYCLES > PROG_CYCLES) ?
                          ((ERASE_CYCLES > PAGE_BYTES) ? ERASE_CYCLES : PAGE_BYTES) :
                          ((PROG_CYCLES > PAGE_BYTES) ? PROG_CYCLES : PAGE_BYTES);
  localparam int CW = $clog2(MAXLEN + 1);

  seq_state_t     state, state_nx;
  logic [PAW-1:0] cur_page;
  logic           cur_rewrite;

  // Named internal events for the checker.
  logic           start, phase_last, done_pulse;
  logic           erase_active, prog_active, load_active;
  logic           erase_we, prog_we, load_we, host_we, in_page;
  logic [CW-1:0]  cnt, phase_len;
  logic [BAW-1:0] offs;
  logic [MAW-1:0] seq_addr, mem_rd_addr;
  logic           mem_we, buf_we;
  logic [DW-1:0]  mem_wdata, buf_wdata, buf_seq_data, mem_seq_data;
  logic [BAW-1:0] buf_waddr;

  assign ready        = (state == ST_IDLE);
  assign start        = ready && req_valid;
  assign erase_active = (state == ST_ERASE);
  assign prog_active  = (state == ST_PROG);
  assign load_active  = (state == ST_LOAD);
  assign done_pulse   = (state == ST_DONE);

  assign phase_len = CW'(phase_cycles(state, PAGE_BYTES, ERASE_CYCLES, PROG_CYCLES));

  page_seq_timer #(.CW(CW)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (ready || phase_last),
    .phase_len (phase_len),
    .cnt       (cnt),
    .last      (phase_last)
  );

  // Next-state logic
  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE:  if (start) state_nx = req_rewrite ? ST_LOAD : ST_ERASE;
      ST_LOAD:  if (phase_last) state_nx = ST_ERASE;
      ST_ERASE: if (phase_last) state_nx = ST_PROG;
      ST_PROG:  if (phase_last) state_nx = ST_DONE;
      ST_DONE:  state_nx = ST_IDLE;
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      cur_page    <= '0;
      cur_rewrite <= 1'b0;
    end else begin
      state <= state_nx;
      if (start) begin
        cur_page    <= req_page;
        cur_rewrite <= req_rewrite;
      end
    end
  end

  // Byte walk: one byte per clock during the leading part of each phase.
  assign in_page  = (cnt < CW'(PAGE_BYTES));
  assign offs     = cnt[BAW-1:0];
  assign seq_addr = MAW'(flat_index(int'(cur_page), int'(offs), PAGE_BYTES));

  assign erase_we = erase_active && in_page;
  assign prog_we  = prog_active  && in_page;
  assign load_we  = load_active  && in_page;
  assign host_we  = buf_wr_en && ready;

  assign mem_we    = erase_we || prog_we;
  assign mem_wdata = erase_we ? '1 : buf_seq_data;

  assign buf_we    = load_we || host_we;
  assign buf_waddr = load_we ? offs : buf_wr_addr;
  assign buf_wdata = load_we ? mem_seq_data : buf_wr_data;

  assign mem_rd_addr = MAW'(flat_index(int'(mem_rd_page), int'(mem_rd_offs), PAGE_BYTES));

  page_seq_array #(.DW(DW), .DEPTH(MDEPTH), .AW(MAW)) u_main (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (mem_we),
    .waddr   (seq_addr),
    .wdata   (mem_wdata),
    .raddr_a (seq_addr),
    .rdata_a (mem_seq_data),
    .raddr_b (mem_rd_addr),
    .rdata_b (mem_rd_data)
  );

  page_seq_array #(.DW(DW), .DEPTH(PAGE_BYTES), .AW(BAW)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (buf_we),
    .waddr   (buf_waddr),
    .wdata   (buf_wdata),
    .raddr_a (offs),
    .rdata_a (buf_seq_data),
    .raddr_b (buf_rd_addr),
    .rdata_b (buf_rd_data)
  );

endmodule

// File: rtl/page_op_seq_chk.sv
module page_op_seq_chk #(
  parameter int PAW = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ready,
  input logic           req_valid,
  input logic [PAW-1:0] cur_page,
  input logic           cur_rewrite,
  input logic           erase_active,
  input logic           prog_active,
  input logic           done_pulse,
  input logic           erase_we,
  input logic           prog_we,
  input logic           load_we,
  input logic           host_we
);

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && req_valid) |=> !ready);  // R2

  AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> (ready || $stable(cur_page)));  // R7

  AST_ERASE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_active) |-> $past(erase_active));  // R4

  AST_WRITE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({erase_we, prog_we, load_we, host_we}));  // R8

  AST_LOAD_REWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    load_we |-> cur_rewrite);  // R5

  AST_DONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> ready);  // R6

endmodule

bind page_op_seq page_op_seq_chk #(.PAW(PAW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ready        (ready),
  .req_valid    (req_valid),
  .cur_page     (cur_page),
  .cur_rewrite  (cur_rewrite),
  .erase_active (erase_active),
  .prog_active  (prog_active),
  .done_pulse   (done_pulse),
  .erase_we     (erase_we),
  .prog_we      (prog_we),
  .load_we      (load_we),
  .host_we      (host_we)
);

// File: tb/page_op_seq_tb.sv
module page_op_seq_tb;

  localparam int CLK_PERIOD = 40;
  localparam int DW  = 8;
  localparam int PB  = 8;
  localparam int PC  = 4;
  localparam int EC  = 12;
  localparam int PCY = 10;
  localparam int BAW = $clog2(PB);
  localparam int PAW = $clog2(PC);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_rewrite = 1'b0;
  logic [PAW-1:0] req_page = '0;
  logic ready;
  logic buf_wr_en = 1'b0;
  logic [BAW-1:0] buf_wr_addr = '0, buf_rd_addr = '0, mem_rd_offs = '0;
  logic [DW-1:0] buf_wr_data = '0, buf_rd_data, mem_rd_data;
  logic [PAW-1:0] mem_rd_page = '0;

  int n_checks = 0, n_err = 0;
  bit finished = 0;
  logic [DW-1:0] exp_mem [PC][PB];
  logic [DW-1:0] exp_buf [PB];

  always #(CLK_PERIOD/2) clk = ~clk;

  page_op_seq #(.DW(DW), .PAGE_BYTES(PB), .PAGE_COUNT(PC),
                .ERASE_CYCLES(EC), .PROG_CYCLES(PCY)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_rewrite(req_rewrite),
    .req_page(req_page), .ready(ready), .buf_wr_en(buf_wr_en),
    .buf_wr_addr(buf_wr_addr), .buf_wr_data(buf_wr_data),
    .buf_rd_addr(buf_rd_addr), .buf_rd_data(buf_rd_data),
    .mem_rd_page(mem_rd_page), .mem_rd_offs(mem_rd_offs), .mem_rd_data(mem_rd_data)
  );

  function automatic int busy_expect(input bit rw);
    return (rw ? PB : 0) + EC + PCY + 1;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic compare_all(input string req);
    bit ok = 1;
    int a = 0, e = 0;
    for (int p = 0; p < PC; p++)
      for (int b = 0; b < PB; b++) begin
        mem_rd_page = PAW'(p); mem_rd_offs = BAW'(b); #1;
        if (ok && mem_rd_data !== exp_mem[p][b]) begin
          ok = 0; a = mem_rd_data; e = exp_mem[p][b];
        end
      end
    for (int b = 0; b < PB; b++) begin
      buf_rd_addr = BAW'(b); #1;
      if (ok && buf_rd_data !== exp_buf[b]) begin
        ok = 0; a = buf_rd_data; e = exp_buf[b];
      end
    end
    check(ok, req, a, e);
  endtask

  task automatic buf_write(input int addr, input logic [DW-1:0] d);
    @(negedge clk);
    buf_wr_en = 1'b1; buf_wr_addr = BAW'(addr); buf_wr_data = d;
    @(negedge clk);
    buf_wr_en = 1'b0;
    exp_buf[addr] = d;
  endtask

  task automatic run_op(input bit rw, input int page, input bit inject);
    int n = 0;
    int lead = rw ? PB : 0;
    @(negedge clk);
    check(ready === 1'b1, "R2 ready before request", ready, 1);
    req_valid = 1'b1; req_rewrite = rw; req_page = PAW'(page);
    @(negedge clk);
    req_valid = 1'b0;
    while (!ready && n < 1000) begin
      n++;
      if (n == lead + EC + 1) begin
        bit ok = 1;
        for (int b = 0; b < PB; b++) begin
          mem_rd_page = PAW'(page); mem_rd_offs = BAW'(b); #1;
          if (mem_rd_data !== '1) ok = 0;
        end
        check(ok, "R4 page erased before program", mem_rd_data, 8'hFF);
      end
      if (inject && n == 3) begin
        req_valid = 1'b1; req_rewrite = 1'b0; req_page = PAW'((page + 1) % PC);
        buf_wr_en = 1'b1; buf_wr_addr = '0; buf_wr_data = ~exp_buf[0];
      end
      if (inject && n == 4) begin
        req_valid = 1'b0; buf_wr_en = 1'b0;
      end
      @(negedge clk);
    end
    check(n == busy_expect(rw), rw ? "R6 rewrite busy length" : "R6 program busy length",
          n, busy_expect(rw));
    if (rw) begin
      for (int b = 0; b < PB; b++) exp_buf[b] = exp_mem[page][b];
    end else begin
      for (int b = 0; b < PB; b++) exp_mem[page][b] = exp_buf[b];
    end
    // A dropped request would start a new operation right away.
    @(negedge clk);
    check(ready === 1'b1, "R7 no late start from dropped request", ready, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_err++; n_checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5eed));
    for (int p = 0; p < PC; p++) for (int b = 0; b < PB; b++) exp_mem[p][b] = '1;
    for (int b = 0; b < PB; b++) exp_buf[b] = '1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(ready === 1'b1, "R1 ready after reset", ready, 1);
    compare_all("R1 arrays erased at reset");

    // Directed: program page 0 with a ramp (R3, R4, R6)
    for (int b = 0; b < PB; b++) buf_write(b, DW'(8'h10 + b));
    compare_all("R8 idle buffer writes land");
    run_op(1'b0, 0, 1'b0);
    compare_all("R3 program copies buffer");

    // Directed: rewrite page 0 after scrambling buffer (R5)
    for (int b = 0; b < PB; b++) buf_write(b, DW'(8'hA0 ^ b));
    run_op(1'b1, 0, 1'b0);
    compare_all("R5 rewrite reloads buffer, memory intact");

    // Directed: last page, with request and buffer write injected while busy (R7, R8)
    for (int b = 0; b < PB; b++) buf_write(b, DW'(8'h5A + 3*b));
    run_op(1'b0, PC - 1, 1'b1);
    compare_all("R7 R8 busy request and buffer write dropped");

    // Random mix
    for (int it = 0; it < 24; it++) begin
      bit rw = $urandom_range(0, 1);
      int pg = $urandom_range(0, PC - 1);
      int nw = $urandom_range(0, PB);
      for (int k = 0; k < nw; k++) buf_write($urandom_range(0, PB - 1), DW'($urandom));
      run_op(rw, pg, !rw && $urandom_range(0, 1));
      compare_all(rw ? "R5 random rewrite" : "R3 random program");
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

endmodule